// File: doc/BRIEF.md
# Code-Group to GMII Receive Framer

This block sits on the receive side of an Ethernet MAC, behind a code-group decoder. Each accepted input is one decoded code group: an 8-bit value, a flag telling control codes from data, and a valid strobe. From this stream the block rebuilds the GMII receive signals: data valid, receive error, the receive byte, and a carrier sense signal that is regenerated locally because the link does not carry it.

The block keeps a single bit of frame state. A start delimiter outside a frame opens a frame, and the start cycle itself is shown as a preamble byte. Data groups inside a frame appear on the byte output. An end delimiter closes the frame. An error-propagation code, or any other control code that turns up inside a frame, is flagged as a receive error while data valid stays high. Outside a frame, every group except a start delimiter is dropped. Groups that arrive without the valid strobe change nothing. Carrier sense is the recovered data valid, stretched over a tail of `CRS_TAIL` earlier accepted groups.

Top module: `cg_gmii_rx_framer`

## Requirements
- R1: While reset is asserted and after it is released, with no group accepted, rx_dv_o, rx_er_o, crs_o and rxd_o are all 0.
- R2: An accepted control group of value 0xFB outside a frame opens a frame. On the next cycle the block shows rx_dv_o=1, rx_er_o=0 and rxd_o=0x55.
- R3: An accepted data group (ctrl flag 0) inside a frame gives rx_dv_o=1, rx_er_o=0 and rxd_o equal to the group's value on the next cycle.
- R4: An accepted control group of value 0xFD inside a frame closes the frame. On the next cycle the block shows rx_dv_o=0, rx_er_o=0 and rxd_o=0.
- R5: An accepted control group of value 0xFE inside a frame gives rx_dv_o=1, rx_er_o=1 and rxd_o=0xFE for that one cycle only, and the frame stays open.
- R6: Any other accepted control group inside a frame, including 0xF7, 0xFB and 0xBC, is reported the same way as R5, with its own value on rxd_o. The frame stays open.
- R7: Outside a frame, every accepted group other than a 0xFB control group is ignored: data, 0xFD, 0xFE and 0xBC all leave rx_dv_o=0, rx_er_o=0 and rxd_o=0, and no frame opens.
- R8: A cycle with cg_valid_i=0 leaves all outputs and the frame state unchanged.
- R9: crs_o is 1 exactly when rx_dv_o is 1 or any of the CRS_TAIL values rx_dv_o held before the last CRS_TAIL accepted groups was 1. With the default of 1, crs_o is rx_dv_o ORed with its value one accepted group earlier.
- R10: rxd_o is 0 whenever rx_dv_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cg_valid_i | input | 1 | A code group is presented this cycle |
| cg_ctrl_i | input | 1 | 1 for a control code, 0 for a data group |
| cg_data_i | input | 8 | Decoded code group value |
| rx_dv_o | output | 1 | Recovered receive data valid |
| rx_er_o | output | 1 | Receive error |
| rxd_o | output | 8 | Receive byte |
| crs_o | output | 1 | Regenerated carrier sense |

## Verification
The bench builds the block with CRS_TAIL=2, so the carrier tail depends on two earlier accepted groups and the generated shift chain is exercised instead of a single flop. Gaps in the valid strobe are placed inside that tail. This shows that carrier sense ages only on accepted groups and not on clock cycles. The delimiter values stay at their defaults, so the bench can place them both inside and outside frames.

// File: rtl/cg_rx_pkg.sv
package cg_rx_pkg;
  localparam int unsigned CG_W = 8;
  typedef logic [CG_W-1:0] cg_byte_t;

  localparam cg_byte_t K_SOP    = 8'hFB;
  localparam cg_byte_t K_EOP    = 8'hFD;
  localparam cg_byte_t K_ERR    = 8'hFE;
  localparam cg_byte_t K_EXT    = 8'hF7;
  localparam cg_byte_t PREAMBLE = 8'h55;

  typedef enum logic [2:0] {
    CG_DATA,
    CG_SOP,
    CG_EOP,
    CG_ERR,
    CG_EXT,
    CG_OTHER
  } cg_class_e;

  typedef enum logic {
    ST_OUT,
    ST_IN
  } frame_st_e;
endpackage

// File: rtl/cg_classify.sv
module cg_classify
  import cg_rx_pkg::*;
(
  input  logic      ctrl_i,
  input  cg_byte_t  data_i,
  output cg_class_e cls_o
);
  always_comb begin
    if (!ctrl_i) begin
      cls_o = CG_DATA;
    end else begin
      unique case (data_i)
        K_SOP:   cls_o = CG_SOP;
        K_EOP:   cls_o = CG_EOP;
        K_ERR:   cls_o = CG_ERR;
        K_EXT:   cls_o = CG_EXT;
        default: cls_o = CG_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import cg_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  cg_class_e cls_i,
  input  cg_byte_t  data_i,
  output logic      rx_dv_o,
  output logic      rx_er_o,
  output cg_byte_t  rxd_o
);
  frame_st_e st_q, st_d;
  logic      dv_d, er_d;
  cg_byte_t  rxd_d;

  always_comb begin
    st_d  = st_q;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    rxd_d = '0;
    if (st_q == ST_OUT) begin
      if (cls_i == CG_SOP) begin
        st_d  = ST_IN;
        dv_d  = 1'b1;
        rxd_d = PREAMBLE;
      end
    end else begin
      unique case (cls_i)
        CG_DATA: begin
          dv_d  = 1'b1;
          rxd_d = data_i;
        end
        CG_EOP: st_d = ST_OUT;
        default: begin
          // error propagation or stray control code
          dv_d  = 1'b1;
          er_d  = 1'b1;
          rxd_d = data_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OUT;
      rx_dv_o <= 1'b0;
      rx_er_o <= 1'b0;
      rxd_o   <= '0;
    end else if (valid_i) begin
      st_q    <= st_d;
      rx_dv_o <= dv_d;
      rx_er_o <= er_d;
      rxd_o   <= rxd_d;
    end
  end

  AST_SOP_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == CG_SOP && st_q == ST_OUT) |=> (rx_dv_o && !rx_er_o && rxd_o == PREAMBLE)); // R2
  AST_EOP_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == CG_EOP && st_q == ST_IN) |=> (!rx_dv_o && st_q == ST_OUT)); // R4
  AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i == CG_ERR && st_q == ST_IN) |=> (rx_dv_o && rx_er_o && st_q == ST_IN)); // R5
  AST_ER_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> rx_dv_o); // R6
  AST_OUT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i != CG_SOP && st_q == ST_OUT) |=> (!rx_dv_o && st_q == ST_OUT)); // R7
  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(rx_dv_o) && $stable(rx_er_o) && $stable(rxd_o) && $stable(st_q))); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_o |-> (rxd_o == '0)); // R10
endmodule

// File: rtl/crs_regen.sv
module crs_regen #(
  parameter int unsigned CRS_TAIL = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic dv_i,
  output logic crs_o
);
  generate
    if (CRS_TAIL == 0) begin : g_direct
      assign crs_o = dv_i;
    end else begin : g_tail
      logic [CRS_TAIL-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else if (valid_i) begin
          if (CRS_TAIL == 1) hist_q <= dv_i;
          else hist_q <= {hist_q[CRS_TAIL-2:0], dv_i};
        end
      end
      assign crs_o = dv_i | (|hist_q);

      AST_CRS_TAIL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dv_i) |-> crs_o); // R9
    end
  endgenerate

  AST_CRS_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rst_ni) && !dv_i) |-> !crs_o); // R1
endmodule

// File: rtl/cg_gmii_rx_framer.sv
module cg_gmii_rx_framer
  import cg_rx_pkg::*;
#(
  parameter int unsigned CRS_TAIL = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cg_valid_i,
  input  logic       cg_ctrl_i,
  input  logic [7:0] cg_data_i,
  output logic       rx_dv_o,
  output logic       rx_er_o,
  output logic [7:0] rxd_o,
  output logic       crs_o
);
  cg_class_e cls;
  logic      dv;

  cg_classify u_cls (
    .ctrl_i (cg_ctrl_i),
    .data_i (cg_data_i),
    .cls_o  (cls)
  );

  rx_frame_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cg_valid_i),
    .cls_i   (cls),
    .data_i  (cg_data_i),
    .rx_dv_o (dv),
    .rx_er_o (rx_er_o),
    .rxd_o   (rxd_o)
  );

  crs_regen #(.CRS_TAIL(CRS_TAIL)) u_crs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cg_valid_i),
    .dv_i    (dv),
    .crs_o   (crs_o)
  );

  assign rx_dv_o = dv;
endmodule

// File: tb/sim_cg_gmii_rx_framer.sv
module sim_cg_gmii_rx_framer;
  localparam int unsigned TAIL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0, c = 1'b0;
  logic [7:0] d = '0;
  logic       dv, er, crs;
  logic [7:0] rxd;

  int total = 0, bad = 0;

  // reference state
  bit       m_in = 0, m_dv = 0, m_er = 0;
  bit [7:0] m_rxd = 0;
  bit       m_hist[$];

  always #2 clk = ~clk;

  cg_gmii_rx_framer #(.CRS_TAIL(TAIL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cg_valid_i(v), .cg_ctrl_i(c), .cg_data_i(d),
    .rx_dv_o(dv), .rx_er_o(er), .rxd_o(rxd), .crs_o(crs)
  );

  function automatic bit m_crs();
    bit r = m_dv;
    foreach (m_hist[i]) r |= m_hist[i];
    return r;
  endfunction

  task automatic model(input bit vv, input bit cc, input bit [7:0] dd);
    if (!vv) return;
    m_hist.push_front(m_dv);
    void'(m_hist.pop_back());
    if (!m_in) begin
      m_er = 0; m_rxd = 0; m_dv = 0;
      if (cc && dd == 8'hFB) begin m_in = 1; m_dv = 1; m_rxd = 8'h55; end
    end else if (!cc) begin
      m_dv = 1; m_er = 0; m_rxd = dd;
    end else if (dd == 8'hFD) begin
      m_in = 0; m_dv = 0; m_er = 0; m_rxd = 0;
    end else begin
      m_dv = 1; m_er = 1; m_rxd = dd;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rx_dv", dv, m_dv);
    chk(tag, "rx_er", er, m_er);
    chk(tag, "rxd", rxd, m_rxd);
    chk("R9", "crs", crs, m_crs());
    if (!dv) chk("R10", "rxd idle", rxd, 0);
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(input bit vv, input bit cc, input bit [7:0] dd, input string tag);
    v = vv; c = cc; d = dd;
    @(posedge clk);
    model(vv, cc, dd);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < TAIL; i++) m_hist.push_back(0);
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R7: junk outside a frame
    step(1, 0, 8'h3C, "R7");
    step(1, 1, 8'hFD, "R7");
    step(1, 1, 8'hFE, "R7");
    step(1, 1, 8'hBC, "R7");
    step(1, 1, 8'hF7, "R7");
    // R2 open, R3 data
    step(1, 1, 8'hFB, "R2");
    step(1, 0, 8'h55, "R3");
    step(1, 0, 8'hD5, "R3");
    step(1, 0, 8'h00, "R3");
    step(1, 0, 8'hFB, "R3");
    // R5 / R6 errors inside
    step(1, 1, 8'hFE, "R5");
    step(1, 0, 8'hA7, "R5");
    step(1, 1, 8'hF7, "R6");
    step(1, 1, 8'hFB, "R6");
    step(1, 1, 8'hBC, "R6");
    step(1, 0, 8'h12, "R6");
    // R8 gaps inside a frame
    step(0, 1, 8'hFD, "R8");
    step(0, 0, 8'h99, "R8");
    step(1, 0, 8'h34, "R3");
    // R4 close, R9 tail with gaps between accepted groups
    step(1, 1, 8'hFD, "R4");
    step(0, 1, 8'hFB, "R8");
    step(1, 1, 8'hBC, "R9");
    step(0, 0, 8'h00, "R8");
    step(1, 1, 8'hBC, "R9");
    step(1, 1, 8'hBC, "R9");
    // back-to-back frames
    step(1, 1, 8'hFB, "R2");
    step(1, 1, 8'hFD, "R4");
    step(1, 1, 8'hFB, "R2");
    step(1, 0, 8'h77, "R3");
    step(1, 1, 8'hFD, "R4");
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] dd;
      bit cc, vv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vv = lfsr[0] | lfsr[1];
      cc = (lfsr[4:2] == 3'd0);
      dd = lfsr[15:8];
      if (lfsr[7:5] == 3'd0) begin cc = 1; dd = 8'hFB; end
      if (lfsr[7:5] == 3'd1) begin cc = 1; dd = 8'hFD; end
      if (lfsr[7:5] == 3'd2 && lfsr[11]) begin cc = 1; dd = 8'hFE; end
      step(vv, cc, dd, "R3");
    end
    // R1 again: reset in mid-frame
    step(1, 1, 8'hFB, "R2");
    rst_n = 1'b0;
    m_in = 0; m_dv = 0; m_er = 0; m_rxd = 0;
    foreach (m_hist[i]) m_hist[i] = 0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1, 0, 8'h42, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule